// File: doc/BRIEF.md
# Banked General-Register File with Overlapping Byte, Word and Extended Views

This block is the general-register store of a small processor core. Eight register banks exist side by side, and a 3-bit bank register chooses which one every access uses. Each bank holds sixteen general byte registers plus four extension bytes. One store backs three views: a byte register, a 16-bit pair formed from two adjacent bytes, and a 24-bit extended register formed from a pair plus one extension byte. A write through any view changes every view that shares its bytes.

Every access carries a 4-bit operand-format code and a 4-bit specification field. A decoder turns them into physical byte slots. The format also fixes the access width. Some formats name a register implicitly: the accumulator, its companion, the two counter bytes and the accumulator pair. A remap input moves those implied names onto a second group of registers, so that code written for an older register layout still runs.

There are two combinational read ports and one write port that updates on the clock edge. The instruction decoder, the ALU and the status word that holds the remap bit live outside this block.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous active-high reset sets the bank register to 0 and clears every byte of every bank. After reset, every format on both ports reads zero.
- R2: Format code 4 selects general byte register Rn, where n is the 4-bit spec. A byte read returns the value in bits 7:0, with bits 23:8 zero.
- R3: Format 5 reaches R0..R7 and format 6 reaches R8..R15, using spec bits 2:0 in both cases. Format 7 reaches the extension bytes V, U, T and W for spec 0..3. All of these name the same storage as format 4.
- R4: Pair n is {R(2n+1), R(2n)}, with the odd register as the high byte. Format 9 selects pair spec[2:0]. Format 10 selects pairs 0..3 and format 11 selects pairs 4..7, both through spec[1:0]. A word read places its value in bits 15:0 and returns zero in bits 23:16. A word write updates both bytes at the same edge.
- R5: Format 13 with spec[1:0]=k selects the 24-bit register {extension byte k, pair 4+k}. Extension byte 0 is V, 1 is U, 2 is T and 3 is W. Format 12 is the implied 24-bit register, which is the k=3 case. A 24-bit write updates all three bytes at the same edge.
- R6: The implied formats are 0=A, 1=X, 2=B, 3=C and 8=AX. With remap 0 they map to R1, R0, R3, R2 and pair 0. With remap 1 they map to R5, R4, R7, R6 and pair 2. Remap is applied combinationally when the access is made.
- R7: When bank_ld_i is high at a clock edge, bank_sel_i is loaded into the bank register, and bank_o shows that register. Otherwise the bank register holds its value. Banks are independent: a write to one bank leaves every other bank unchanged.
- R8: Reads are combinational. A read in the same cycle as a write to the same register returns the old value, and the new value appears after the edge. The two read ports select and return data independently.
- R9: Format codes 14 and 15 are invalid. They read as zero and their writes change nothing. When wr_en_i is low, nothing is stored.
- R10: A write stores only as many low bits of wr_data_i as its format width. The remaining data bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bank_ld_i | input | 1 | Load the bank register |
| bank_sel_i | input | 3 | New bank number |
| remap_i | input | 1 | Moves the implied registers to their alternate group |
| wr_en_i | input | 1 | Write enable |
| wr_fmt_i | input | 4 | Write operand format |
| wr_spec_i | input | 4 | Write register specification |
| wr_data_i | input | 24 | Write data, low bits used |
| rda_fmt_i | input | 4 | Read port A format |
| rda_spec_i | input | 4 | Read port A specification |
| rda_data_o | output | 24 | Read port A data, zero-extended |
| rdb_fmt_i | input | 4 | Read port B format |
| rdb_spec_i | input | 4 | Read port B specification |
| rdb_data_o | output | 24 | Read port B data, zero-extended |
| bank_o | output | 3 | Current bank |

## Verification
The stability assertion on port A assumes that only a write, a bank load or a change of the remap, format or spec inputs can alter that port's output. The bench therefore changes these inputs only at falling edges and holds them steady across each rising edge. The width assertions assume that the format input alone fixes the read width, including the invalid codes, so the stimulus deliberately drives codes 14 and 15 on both ports. The bench returns reset low only after several edges, so the stability check never compares against storage that has not yet been cleared.

// File: rtl/brf_pkg.sv
package brf_pkg;

    localparam int NUM_BANKS  = 8;
    localparam int BANK_W     = $clog2(NUM_BANKS);
    localparam int GP_REGS    = 16;
    localparam int EXT_REGS   = 4;
    localparam int SLOTS      = GP_REGS + EXT_REGS;
    localparam int SLOT_W     = $clog2(SLOTS);
    localparam int BYTE_W     = 8;
    localparam int LANES      = 3;
    localparam int DATA_W     = LANES * BYTE_W;
    localparam int FMT_W      = 4;
    localparam int SPEC_W     = 4;
    localparam int REMAP_OFS  = 4;   // byte offset of the alternate implied group
    localparam int EXT_PAIR0  = 4;   // first pair that extends to 24 bits

    typedef enum logic [FMT_W-1:0] {
        FMT_A    = 4'd0,
        FMT_X    = 4'd1,
        FMT_B    = 4'd2,
        FMT_C    = 4'd3,
        FMT_R    = 4'd4,
        FMT_RLO  = 4'd5,
        FMT_RHI  = 4'd6,
        FMT_RX   = 4'd7,
        FMT_AX   = 4'd8,
        FMT_RP   = 4'd9,
        FMT_RPLO = 4'd10,
        FMT_RPHI = 4'd11,
        FMT_WHL  = 4'd12,
        FMT_RG   = 4'd13
    } fmt_e;

    typedef logic [SLOT_W-1:0] slot_t;

    // Physical location of an operand: which byte lanes exist and their slots
    typedef struct packed {
        logic [LANES-1:0]             lane_en;
        logic [LANES-1:0][SLOT_W-1:0] slot;
    } loc_t;

    function automatic loc_t byte_loc(input slot_t s);
        loc_t l;
        l         = '0;
        l.lane_en = LANES'(1);
        l.slot[0] = s;
        return l;
    endfunction

    function automatic loc_t pair_loc(input logic [2:0] n);
        loc_t l;
        l         = '0;
        l.lane_en = LANES'(3);
        l.slot[0] = slot_t'({n, 1'b0});
        l.slot[1] = slot_t'({n, 1'b1});
        return l;
    endfunction

    function automatic loc_t ext_loc(input logic [1:0] k);
        loc_t l;
        l         = pair_loc(3'(EXT_PAIR0) + {1'b0, k});
        l.lane_en = LANES'(7);
        l.slot[2] = slot_t'(GP_REGS) + slot_t'(k);
        return l;
    endfunction

    // Access width in bytes for a format code, 0 when the code is invalid
    function automatic int unsigned fmt_bytes(input logic [FMT_W-1:0] f);
        if (f <= FMT_RX)  return 1;
        if (f <= FMT_RPHI) return 2;
        if (f <= FMT_RG)  return 3;
        return 0;
    endfunction

endpackage

// File: rtl/brf_bank_ctl.sv
module brf_bank_ctl #(
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [BANK_W-1:0] sel,
    output logic [BANK_W-1:0] bank
);
    always_ff @(posedge clk) begin
        if (rst)     bank <= '0;
        else if (ld) bank <= sel;
    end
endmodule

// File: rtl/brf_opdec.sv
module brf_opdec
    import brf_pkg::*;
(
    input  logic [FMT_W-1:0]  fmt,
    input  logic [SPEC_W-1:0] spec,
    input  logic              remap,
    output loc_t              loc
);
    slot_t      ofs;
    logic [2:0] acc_pair;

    assign ofs      = remap ? slot_t'(REMAP_OFS) : '0;
    assign acc_pair = remap ? 3'(REMAP_OFS / 2) : 3'd0;

    always_comb begin
        case (fmt_e'(fmt))
            FMT_X:    loc = byte_loc(slot_t'(0) + ofs);
            FMT_A:    loc = byte_loc(slot_t'(1) + ofs);
            FMT_C:    loc = byte_loc(slot_t'(2) + ofs);
            FMT_B:    loc = byte_loc(slot_t'(3) + ofs);
            FMT_R:    loc = byte_loc(slot_t'(spec));
            FMT_RLO:  loc = byte_loc(slot_t'(spec[2:0]));
            FMT_RHI:  loc = byte_loc(slot_t'({1'b1, spec[2:0]}));
            FMT_RX:   loc = byte_loc(slot_t'(GP_REGS) + slot_t'(spec[1:0]));
            FMT_AX:   loc = pair_loc(acc_pair);
            FMT_RP:   loc = pair_loc(spec[2:0]);
            FMT_RPLO: loc = pair_loc({1'b0, spec[1:0]});
            FMT_RPHI: loc = pair_loc({1'b1, spec[1:0]});
            FMT_WHL:  loc = ext_loc(2'd3);
            FMT_RG:   loc = ext_loc(spec[1:0]);
            default:  loc = '0;
        endcase
    end
endmodule

// File: rtl/brf_store.sv
module brf_store
    import brf_pkg::*;
#(
    parameter int BANKS  = 8,
    parameter int NSLOTS = 20,
    parameter int RPORTS = 2,
    localparam int BW    = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BW-1:0]     bank,
    input  logic              we,
    input  loc_t              wloc,
    input  logic [DATA_W-1:0] wdata,
    input  loc_t              rloc  [RPORTS],
    output logic [DATA_W-1:0] rdata [RPORTS]
);
    logic [BYTE_W-1:0] mem [BANKS][NSLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < BANKS; b++)
                for (int s = 0; s < NSLOTS; s++)
                    mem[b][s] <= '0;
        end else if (we) begin
            for (int l = 0; l < LANES; l++)
                if (wloc.lane_en[l])
                    mem[bank][wloc.slot[l]] <= wdata[l*BYTE_W +: BYTE_W];
        end
    end

    for (genvar p = 0; p < RPORTS; p++) begin : g_rd
        always_comb begin
            rdata[p] = '0;
            for (int l = 0; l < LANES; l++)
                if (rloc[p].lane_en[l])
                    rdata[p][l*BYTE_W +: BYTE_W] = mem[bank][rloc[p].slot[l]];
        end
    end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import brf_pkg::*;
#(
    parameter int N_BANKS = NUM_BANKS,
    localparam int BW     = $clog2(N_BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bank_ld_i,
    input  logic [BW-1:0]     bank_sel_i,
    input  logic              remap_i,
    input  logic              wr_en_i,
    input  logic [FMT_W-1:0]  wr_fmt_i,
    input  logic [SPEC_W-1:0] wr_spec_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [FMT_W-1:0]  rda_fmt_i,
    input  logic [SPEC_W-1:0] rda_spec_i,
    output logic [DATA_W-1:0] rda_data_o,
    input  logic [FMT_W-1:0]  rdb_fmt_i,
    input  logic [SPEC_W-1:0] rdb_spec_i,
    output logic [DATA_W-1:0] rdb_data_o,
    output logic [BW-1:0]     bank_o
);
    localparam int RPORTS = 2;

    logic [FMT_W-1:0]  rd_fmt  [RPORTS];
    logic [SPEC_W-1:0] rd_spec [RPORTS];
    loc_t              rd_loc  [RPORTS];
    logic [DATA_W-1:0] rd_data [RPORTS];
    loc_t              wr_loc;

    assign rd_fmt[0]  = rda_fmt_i;
    assign rd_spec[0] = rda_spec_i;
    assign rd_fmt[1]  = rdb_fmt_i;
    assign rd_spec[1] = rdb_spec_i;
    assign rda_data_o = rd_data[0];
    assign rdb_data_o = rd_data[1];

    brf_bank_ctl #(.BANK_W(BW)) bank_i (
        .clk  (clk),
        .rst  (rst),
        .ld   (bank_ld_i),
        .sel  (bank_sel_i),
        .bank (bank_o)
    );

    brf_opdec wdec_i (
        .fmt   (wr_fmt_i),
        .spec  (wr_spec_i),
        .remap (remap_i),
        .loc   (wr_loc)
    );

    for (genvar p = 0; p < RPORTS; p++) begin : g_rdec
        brf_opdec rdec_i (
            .fmt   (rd_fmt[p]),
            .spec  (rd_spec[p]),
            .remap (remap_i),
            .loc   (rd_loc[p])
        );
    end

    brf_store #(
        .BANKS  (N_BANKS),
        .NSLOTS (SLOTS),
        .RPORTS (RPORTS)
    ) store_i (
        .clk   (clk),
        .rst   (rst),
        .bank  (bank_o),
        .we    (wr_en_i),
        .wloc  (wr_loc),
        .wdata (wr_data_i),
        .rloc  (rd_loc),
        .rdata (rd_data)
    );
endmodule

// File: rtl/brf_checker.sv
module brf_checker
    import brf_pkg::*;
#(
    parameter int BW = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              bank_ld_i,
    input logic [BW-1:0]     bank_sel_i,
    input logic              remap_i,
    input logic              wr_en_i,
    input logic [FMT_W-1:0]  rda_fmt_i,
    input logic [SPEC_W-1:0] rda_spec_i,
    input logic [DATA_W-1:0] rda_data_o,
    input logic [FMT_W-1:0]  rdb_fmt_i,
    input logic [DATA_W-1:0] rdb_data_o,
    input logic [BW-1:0]     bank_o
);
    assert_bank_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> bank_o == '0);

    assert_bank_load_R7: assert property (@(posedge clk) disable iff (rst)
        bank_ld_i |=> bank_o == $past(bank_sel_i));

    assert_bank_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !bank_ld_i |=> $stable(bank_o));

    assert_byte_width_R2: assert property (@(posedge clk) disable iff (rst)
        fmt_bytes(rdb_fmt_i) == 1 |-> rdb_data_o[DATA_W-1:BYTE_W] == '0);

    assert_word_width_R4: assert property (@(posedge clk) disable iff (rst)
        fmt_bytes(rda_fmt_i) == 2 |-> rda_data_o[DATA_W-1:2*BYTE_W] == '0);

    assert_invalid_zero_R9: assert property (@(posedge clk) disable iff (rst)
        fmt_bytes(rdb_fmt_i) == 0 |-> rdb_data_o == '0);

    assert_read_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en_i) && !$past(bank_ld_i) && $stable(remap_i)
         && $stable(rda_fmt_i) && $stable(rda_spec_i)) |-> $stable(rda_data_o));
endmodule

bind banked_regfile brf_checker #(.BW(BW)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .bank_ld_i  (bank_ld_i),
    .bank_sel_i (bank_sel_i),
    .remap_i    (remap_i),
    .wr_en_i    (wr_en_i),
    .rda_fmt_i  (rda_fmt_i),
    .rda_spec_i (rda_spec_i),
    .rda_data_o (rda_data_o),
    .rdb_fmt_i  (rdb_fmt_i),
    .rdb_data_o (rdb_data_o),
    .bank_o     (bank_o)
);

// File: tb/banked_regfile_tb_top.sv
module banked_regfile_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 0;
    logic        rst = 1;
    logic        bank_ld_i = 0;
    logic [2:0]  bank_sel_i = 0;
    logic        remap_i = 0;
    logic        wr_en_i = 0;
    logic [3:0]  wr_fmt_i = 0, wr_spec_i = 0;
    logic [23:0] wr_data_i = 0;
    logic [3:0]  rda_fmt_i = 0, rda_spec_i = 0, rdb_fmt_i = 0, rdb_spec_i = 0;
    logic [23:0] rda_data_o, rdb_data_o;
    logic [2:0]  bank_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_regfile dut_i (.*);

    // wr, requirement number, format, spec, data (write) or expected (read)
    typedef struct packed {
        logic        wr;
        logic [3:0]  req;
        logic [3:0]  fmt;
        logic [3:0]  spec;
        logic [23:0] val;
    } vec_t;

    localparam int NVEC = 20;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 4'd2,  4'd4,  4'd5,  24'hAAAA5A},  // R10: only the low byte lands in R5
        '{1'b0, 4'd2,  4'd4,  4'd5,  24'h00005A},  // R2
        '{1'b0, 4'd3,  4'd5,  4'd5,  24'h00005A},  // R3 low-half format
        '{1'b1, 4'd3,  4'd6,  4'd3,  24'h000011},  // R3 writes R11
        '{1'b0, 4'd3,  4'd4,  4'd11, 24'h000011},
        '{1'b1, 4'd4,  4'd9,  4'd6,  24'h003412},  // R4 pair 6
        '{1'b0, 4'd4,  4'd4,  4'd12, 24'h000012},
        '{1'b0, 4'd4,  4'd4,  4'd13, 24'h000034},
        '{1'b0, 4'd4,  4'd11, 4'd2,  24'h003412},
        '{1'b1, 4'd5,  4'd7,  4'd2,  24'h000077},  // R5 extension byte T
        '{1'b0, 4'd5,  4'd13, 4'd2,  24'h773412},
        '{1'b1, 4'd5,  4'd13, 4'd3,  24'hC0FFEE},
        '{1'b0, 4'd5,  4'd4,  4'd15, 24'h0000FF},
        '{1'b0, 4'd5,  4'd4,  4'd14, 24'h0000EE},
        '{1'b0, 4'd5,  4'd7,  4'd3,  24'h0000C0},
        '{1'b0, 4'd5,  4'd12, 4'd0,  24'hC0FFEE},
        '{1'b1, 4'd4,  4'd10, 4'd1,  24'h00BEEF},  // pair 1 = {R3,R2}
        '{1'b0, 4'd6,  4'd3,  4'd0,  24'h0000EF},  // R6 implied C -> R2
        '{1'b0, 4'd6,  4'd2,  4'd0,  24'h0000BE},  // R6 implied B -> R3
        '{1'b0, 4'd4,  4'd9,  4'd1,  24'h00BEEF}
    };

    task automatic check(input string tag, input logic [23:0] got, input logic [23:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] f, input logic [3:0] s, input logic [23:0] d);
        @(negedge clk);
        wr_en_i = 1; wr_fmt_i = f; wr_spec_i = s; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 0;
    endtask

    task automatic rda(input string tag, input logic [3:0] f, input logic [3:0] s,
                       input logic [23:0] exp);
        rda_fmt_i = f; rda_spec_i = s;
        #1;
        check(tag, rda_data_o, exp);
    endtask

    task automatic rdb(input string tag, input logic [3:0] f, input logic [3:0] s,
                       input logic [23:0] exp);
        rdb_fmt_i = f; rdb_spec_i = s;
        #1;
        check(tag, rdb_data_o, exp);
    endtask

    task automatic load_bank(input logic [2:0] b);
        @(negedge clk);
        bank_ld_i = 1; bank_sel_i = b;
        @(negedge clk);
        bank_ld_i = 0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        #1;
        // R1 reset state
        check("R1 bank", 24'(bank_o), 24'h0);
        rda("R1 R0", 4'd4, 4'd0, 24'h0);
        rda("R1 ext3", 4'd13, 4'd3, 24'h0);
        rdb("R1 pair7", 4'd9, 4'd7, 24'h0);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].wr) wr(VEC[i].fmt, VEC[i].spec, VEC[i].val);
            else begin
                rda_fmt_i = VEC[i].fmt; rda_spec_i = VEC[i].spec;
                #1;
                n_chk++;
                if (rda_data_o !== VEC[i].val) begin
                    n_fail++;
                    $display("FAIL R%0d vec %0d: got %h expected %h",
                             VEC[i].req, i, rda_data_o, VEC[i].val);
                end
            end
        end

        // R6 implied operands and remap
        remap_i = 0;
        wr(4'd0, 4'd0, 24'h000021);           // A -> R1
        wr(4'd1, 4'd0, 24'h000020);           // X -> R0
        rda("R6 AX remap0", 4'd8, 4'd0, 24'h002120);
        rda("R6 R1", 4'd4, 4'd1, 24'h000021);
        @(negedge clk) remap_i = 1;
        rda("R6 A remap1", 4'd0, 4'd0, 24'h00005A);
        rda("R6 C remap1", 4'd3, 4'd0, 24'h000000);
        wr(4'd8, 4'd0, 24'h009988);           // AX -> pair 2
        rda("R6 R5", 4'd4, 4'd5, 24'h000099);
        rda("R6 R4", 4'd4, 4'd4, 24'h000088);
        rda("R6 X remap1", 4'd1, 4'd0, 24'h000088);
        rda("R6 pair0 kept", 4'd9, 4'd0, 24'h002120);
        @(negedge clk) remap_i = 0;
        rda("R6 A remap0", 4'd0, 4'd0, 24'h000021);

        // R7 banks
        load_bank(3'd3);
        #1 check("R7 bank3", 24'(bank_o), 24'h3);
        rda("R7 fresh bank", 4'd4, 4'd5, 24'h0);
        wr(4'd4, 4'd5, 24'h000044);
        rda("R7 bank3 R5", 4'd4, 4'd5, 24'h000044);
        load_bank(3'd0);
        #1 check("R7 bank0", 24'(bank_o), 24'h0);
        rda("R7 bank0 R5 kept", 4'd4, 4'd5, 24'h000099);

        // R8 write/read same cycle, independent ports
        @(negedge clk);
        wr_en_i = 1; wr_fmt_i = 4'd4; wr_spec_i = 4'd0; wr_data_i = 24'h000055;
        rdb_fmt_i = 4'd4; rdb_spec_i = 4'd0;
        rda_fmt_i = 4'd4; rda_spec_i = 4'd13;
        #1;
        check("R8 old value", rdb_data_o, 24'h000020);
        check("R8 port A", rda_data_o, 24'h000034);
        @(negedge clk) wr_en_i = 0;
        #1 check("R8 new value", rdb_data_o, 24'h000055);

        // R9 invalid formats and disabled write
        wr(4'd14, 4'd5, 24'hFFFFFF);
        rda("R9 R5 kept", 4'd4, 4'd5, 24'h000099);
        rda("R9 R0 kept", 4'd4, 4'd0, 24'h000055);
        rda("R9 read 15", 4'd15, 4'd0, 24'h0);
        rdb("R9 read 14", 4'd14, 4'd5, 24'h0);
        @(negedge clk);
        wr_fmt_i = 4'd4; wr_spec_i = 4'd5; wr_data_i = 24'h000012;
        @(negedge clk);
        rda("R9 wr_en low", 4'd4, 4'd5, 24'h000099);

        // R10 narrow writes ignore upper data
        wr(4'd4, 4'd7, 24'hFFFF33);
        rda("R10 R6 untouched", 4'd4, 4'd6, 24'h0);
        rda("R10 pair3", 4'd9, 4'd3, 24'h003300);
        wr(4'd10, 4'd3, 24'hAB1234);
        rda("R10 pair write", 4'd9, 4'd3, 24'h001234);
        rda("R10 pair neighbour", 4'd4, 4'd8, 24'h0);

        // R1 reset again
        load_bank(3'd2);
        @(negedge clk) rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        #1 check("R1 bank after reset", 24'(bank_o), 24'h0);
        rda("R1 R5 cleared", 4'd4, 4'd5, 24'h0);
        rda("R1 ext cleared", 4'd12, 4'd0, 24'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule